// File: doc/BRIEF.md
# Single-Level Page Table Address Translator

This block turns a virtual address into a physical address by walking a flat, array-style page table that lives in memory. A requester hands it a virtual address together with the kind of access: read or write, user or supervisor. The unit splits the address into a page number and a byte offset. It forms the address of the matching 4-byte table entry from a base register, reads that entry over a simple memory read port, and then answers with either a physical address or a fault code.

Nothing is cached, so every request costs one table read. The unit holds one request at a time. The entry keeps its flag bits in fixed positions: present in bit 0, writable in bit 1, user-accessible in bit 2, and the frame number in bits 31:12. Bits 3 to 8 hold caching, accessed, dirty and global attributes. The unit reads these attribute bits but never acts on them.

Requests enter on a valid/ready pair. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle. Responses leave on a valid/ready pair. Once `resp_valid` rises, `resp_paddr` and `resp_fault` hold steady until the edge on which `resp_ready` is seen high. While a response waits, no new request is taken, so a stalled consumer holds back the requester.

Top module: `lpt_translator`

## Requirements
- R1: The low `OFF_W` bits of the virtual address form the offset, and this offset appears unchanged as the low bits of a successful physical address. The remaining upper bits form the page number. With the defaults this is a 20-bit page number and a 12-bit offset.
- R2: The cycle after a request is accepted, `mem_req` is high for exactly one cycle. During that cycle `mem_addr` equals the base register plus four times the page number.
- R3: `req_ready` is high exactly when no request is in progress. Only one request is handled at a time. A new request can be accepted on the edge right after a response completes.
- R4: The unit waits any number of cycles for `mem_rvalid` after the fetch cycle. A `mem_rvalid` that comes while no entry is awaited is ignored, including one in the fetch cycle itself.
- R5: If the entry is usable, the response carries fault code 0. The physical address is the frame number from entry bits 31:12, cut to `PA_W-OFF_W` bits, placed above the offset.
- R6: If entry bit 0 (present) is clear, the fault code is 1 and the physical address is zero. This holds whatever the permission bits say.
- R7: If the entry is present, fault code 2 is returned with a zero physical address in either of two cases: a write to an entry whose bit 1 is clear, or a user access to an entry whose bit 2 is clear. A supervisor read of a present entry always succeeds.
- R8: `resp_valid`, `resp_paddr` and `resp_fault` stay steady until `resp_ready` is high at a clock edge.
- R9: A write on the base port takes effect only while the unit is idle. It is ignored while a request is in progress. A request accepted on the same edge as a base write uses the old base.
- R10: After reset, `req_ready` is 1, `resp_valid` and `mem_req` are 0, and the base register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | MA_W | New table base value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_paddr | output | PA_W | Physical address (zero on a fault) |
| resp_fault | output | 2 | 0 ok, 1 not present, 2 permission denied |
| mem_req | output | 1 | One-cycle read strobe for the table entry |
| mem_addr | output | MA_W | Table entry address |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Table entry contents |

## Verification
The hardest cases to reach are the timing ones. One is a `mem_rvalid` that arrives in the fetch cycle or while the unit is idle. Another is a base write that lands while a walk is in flight, or on the very edge a request is accepted. The bench's memory model can answer after a chosen latency and can inject stray read-valid pulses on command. The stimulus also pulses the base write port mid-walk and in the acceptance cycle. A behavioural model tracks which base value each walk should use and when each output should change, and every cycle is checked against it.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

  // Response fault codes
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_INVALID = 2'd1,
    FLT_PROT    = 2'd2
  } fault_e;

  // Walk sequencing
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } walk_state_e;

  localparam int ENTRY_BYTES_LOG2 = 2;
  localparam int PFN_FIELD_W      = 20;

  // Page table entry, bit 0 at the bottom
  typedef struct packed {
    logic [PFN_FIELD_W-1:0] frame;
    logic [2:0]             spare;
    logic                   glob;
    logic                   attr_pat;
    logic                   dirty;
    logic                   accessed;
    logic                   no_cache;
    logic                   wr_through;
    logic                   user_ok;
    logic                   write_ok;
    logic                   present;
  } pte_t;

endpackage

// File: rtl/lpt_addr_gen.sv
module lpt_addr_gen
  import lpt_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int MA_W  = 32
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [MA_W-1:0]  base_i,
  output logic [OFF_W-1:0] offset_o,
  output logic [MA_W-1:0]  entry_addr_o
);
  localparam int PN_W = VA_W - OFF_W;

  logic [PN_W-1:0] page_num;

  assign page_num = vaddr_i[VA_W-1:OFF_W];
  assign offset_o = vaddr_i[OFF_W-1:0];

  // Entry address: base plus page number times entry size
  assign entry_addr_o = base_i + (MA_W'(page_num) << ENTRY_BYTES_LOG2);

endmodule

// File: rtl/lpt_perm_check.sv
module lpt_perm_check
  import lpt_pkg::*;
#(
  parameter int OFF_W = 12,
  parameter int PA_W  = 32
) (
  input  pte_t             entry_i,
  input  logic             is_write_i,
  input  logic             is_user_i,
  input  logic [OFF_W-1:0] offset_i,
  output fault_e           fault_o,
  output logic [PA_W-1:0]  paddr_o
);
  localparam int FRAME_W = PA_W - OFF_W;

  logic [FRAME_W-1:0] frame;
  logic               deny;

  generate
    if (FRAME_W <= PFN_FIELD_W) begin : g_trunc
      assign frame = entry_i.frame[FRAME_W-1:0];
      if (FRAME_W < PFN_FIELD_W) begin : g_drop
        logic unused_hi;
        assign unused_hi = ^entry_i.frame[PFN_FIELD_W-1:FRAME_W];
      end
    end else begin : g_ext
      assign frame = FRAME_W'(entry_i.frame);
    end
  endgenerate

  logic unused_attr;
  assign unused_attr = ^{entry_i.spare, entry_i.glob, entry_i.attr_pat, entry_i.dirty,
                         entry_i.accessed, entry_i.no_cache, entry_i.wr_through};

  assign deny = (is_write_i && !entry_i.write_ok) || (is_user_i && !entry_i.user_ok);

  // Presence is judged before permission
  always_comb begin
    fault_o = FLT_NONE;
    paddr_o = '0;
    if (!entry_i.present) begin
      fault_o = FLT_INVALID;
    end else if (deny) begin
      fault_o = FLT_PROT;
    end else begin
      paddr_o = {frame, offset_i};
    end
  end

endmodule

// File: rtl/lpt_translator.sv
module lpt_translator
  import lpt_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PA_W  = 32,
  parameter int MA_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [MA_W-1:0]  base_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic             req_write,
  input  logic             req_user,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [PA_W-1:0]  resp_paddr,
  output logic [1:0]       resp_fault,
  output logic             mem_req,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_rvalid,
  input  logic [31:0]      mem_rdata
);

  walk_state_e      state_q;
  logic [MA_W-1:0]  base_q;
  logic [MA_W-1:0]  entry_addr_q;
  logic [OFF_W-1:0] off_q;
  logic             wr_q;
  logic             usr_q;
  logic [PA_W-1:0]  paddr_q;
  fault_e           fault_q;

  logic [OFF_W-1:0] off_d;
  logic [MA_W-1:0]  entry_addr_d;
  fault_e           fault_d;
  logic [PA_W-1:0]  paddr_d;
  logic             accept;

  lpt_addr_gen #(.VA_W(VA_W), .OFF_W(OFF_W), .MA_W(MA_W)) u_addr (
    .vaddr_i      (req_vaddr),
    .base_i       (base_q),
    .offset_o     (off_d),
    .entry_addr_o (entry_addr_d)
  );

  lpt_perm_check #(.OFF_W(OFF_W), .PA_W(PA_W)) u_perm (
    .entry_i    (pte_t'(mem_rdata)),
    .is_write_i (wr_q),
    .is_user_i  (usr_q),
    .offset_i   (off_q),
    .fault_o    (fault_d),
    .paddr_o    (paddr_d)
  );

  assign accept = req_valid && (state_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      base_q       <= '0;
      entry_addr_q <= '0;
      off_q        <= '0;
      wr_q         <= 1'b0;
      usr_q        <= 1'b0;
      paddr_q      <= '0;
      fault_q      <= FLT_NONE;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (base_we) base_q <= base_wdata;
          if (accept) begin
            entry_addr_q <= entry_addr_d;
            off_q        <= off_d;
            wr_q         <= req_write;
            usr_q        <= req_user;
            state_q      <= ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rvalid) begin
            paddr_q <= paddr_d;
            fault_q <= fault_d;
            state_q <= ST_RESP;
          end
        end
        ST_RESP: if (resp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_FETCH);
  assign mem_addr   = entry_addr_q;
  assign resp_valid = (state_q == ST_RESP);
  assign resp_paddr = paddr_q;
  assign resp_fault = fault_q;

  // R2
  fetch_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> mem_req);

  // R2
  single_fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R4
  resp_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_valid) |-> $past(mem_rvalid));

  // R8
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_paddr) && $stable(resp_fault)));

  // R6
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault != 2'd0) |-> (resp_paddr == '0));

  // R9
  base_frozen_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(base_q));

endmodule

// File: tb/lpt_translator_tb.sv
module lpt_translator_tb;
  localparam int VA_W = 6;
  localparam int OFF_W = 4;
  localparam int PA_W = 7;
  localparam int MA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_we = 1'b0;
  logic [MA_W-1:0] base_wdata = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [VA_W-1:0] req_vaddr = '0;
  logic req_write = 1'b0;
  logic req_user = 1'b0;
  logic resp_valid;
  logic resp_ready = 1'b1;
  logic [PA_W-1:0] resp_paddr;
  logic [1:0] resp_fault;
  logic mem_req;
  logic [MA_W-1:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  lpt_translator #(.VA_W(VA_W), .OFF_W(OFF_W), .PA_W(PA_W), .MA_W(MA_W)) u_dut (.*);

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 0;
  string addr_tag = "R2";

  // Memory model controls
  logic [31:0] tab [4];
  int lat = 1;
  bit spur_fetch = 0;
  bit spur_idle = 0;

  // Reference model state
  int m_phase = 0;
  logic [MA_W-1:0] m_base = '0;
  logic [MA_W-1:0] m_eaddr = '0;
  int m_off = 0;
  bit m_wr = 0, m_us = 0;
  int m_fault = 0;
  int m_paddr = 0;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic string res_tag(input int f);
    if (f == 1) return "R6";
    if (f == 2) return "R7";
    return "R5";
  endfunction

  // Behavioural reference updated at every edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_phase = 0;
      m_base = '0;
    end else begin
      case (m_phase)
        0: begin
          if (req_valid) begin
            m_eaddr = m_base + 32'(req_vaddr >> OFF_W) * 4;
            m_off = int'(req_vaddr) % (1 << OFF_W);
            m_wr = req_write;
            m_us = req_user;
            m_phase = 1;
          end
          if (base_we) m_base = base_wdata;
        end
        1: m_phase = 2;
        2: if (mem_rvalid) begin
          if (!mem_rdata[0]) begin m_fault = 1; m_paddr = 0; end
          else if ((m_wr && !mem_rdata[1]) || (m_us && !mem_rdata[2])) begin
            m_fault = 2; m_paddr = 0;
          end else begin
            m_fault = 0;
            m_paddr = (int'(mem_rdata >> 12) % (1 << (PA_W - OFF_W))) * (1 << OFF_W) + m_off;
          end
          m_phase = 3;
        end
        default: if (resp_ready) m_phase = 0;
      endcase
    end
  end

  // Per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3", req_ready, m_phase == 0);
      chk("R2", mem_req, m_phase == 1);
      chk(m_phase == 2 ? "R4" : "R8", resp_valid, m_phase == 3);
      if (m_phase == 1) chk(addr_tag, mem_addr, m_eaddr);
      if (m_phase == 3) begin
        chk(res_tag(m_fault), resp_fault, m_fault);
        chk(res_tag(m_fault), resp_paddr, m_paddr);
        if (m_fault == 0) chk("R1", resp_paddr % (1 << OFF_W), m_off);
      end
    end
  end

  // Memory responder
  initial begin
    bit pend = 0;
    int cnt = 0;
    int idx = 0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      mem_rdata = 32'hDEAD_0000;
      if (pend) begin
        if (cnt <= 1) begin
          mem_rvalid = 1'b1;
          mem_rdata = tab[idx];
          pend = 0;
        end else cnt--;
      end else if (mem_req) begin
        pend = 1;
        cnt = lat;
        idx = int'(mem_addr[3:2]);
        if (spur_fetch) begin mem_rvalid = 1'b1; mem_rdata = 32'h0000_0000; end
      end else if (spur_idle) begin
        mem_rvalid = 1'b1;
        mem_rdata = 32'h0000_0000;
      end
    end
  end

  task automatic do_req(input logic [VA_W-1:0] va, input bit wr, input bit us, input int stall);
    while (!req_ready) @(negedge clk);
    req_vaddr = va;
    req_write = wr;
    req_user = us;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    if (stall > 0) begin
      resp_ready = 1'b0;
      repeat (stall) @(negedge clk);
      resp_ready = 1'b1;
    end
    @(negedge clk);
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    tab[0] = 32'h0000_3007;  // frame 3, present, writable, user
    tab[1] = 32'h0000_7007;  // frame 7, present, writable, user
    tab[2] = 32'h0000_5001;  // frame 5, present, read-only, supervisor
    tab[3] = 32'h0000_2006;  // not present, permissions set
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state at the ports
    chk("R10", req_ready, 1);
    chk("R10", resp_valid, 0);
    chk("R10", mem_req, 0);
    // R10 base zero: page 1 entry at address 4; address 21 -> 117 (R5, R1)
    addr_tag = "R10";
    do_req(6'd21, 0, 0, 0);
    chk("R5", int'(u_dut.resp_paddr) == 0 ? 0 : 1, 1);
    addr_tag = "R2";
    // Load the base while idle
    base_we = 1'b1; base_wdata = 32'h100;
    @(negedge clk);
    base_we = 1'b0;
    do_req(6'd21, 1, 1, 0);
    do_req(6'd3, 0, 1, 0);
    // R4 long latency and stray read-valid pulses
    lat = 5; spur_fetch = 1;
    do_req(6'd47, 0, 0, 0);
    spur_fetch = 0; spur_idle = 1;
    repeat (3) @(negedge clk);
    spur_idle = 0;
    lat = 1;
    // R7 permission cases on page 2
    do_req(6'd40, 1, 0, 0);
    do_req(6'd41, 0, 1, 0);
    do_req(6'd42, 0, 0, 0);
    do_req(6'd33, 1, 1, 0);
    // R6 absent page with permissions set
    do_req(6'd60, 1, 1, 0);
    do_req(6'd48, 0, 0, 0);
    // R8 consumer stall
    do_req(6'd18, 0, 0, 3);
    do_req(6'd52, 1, 0, 2);
    // R9 base write mid-walk is ignored
    addr_tag = "R9";
    lat = 4;
    req_vaddr = 6'd37; req_write = 0; req_user = 0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    base_we = 1'b1; base_wdata = 32'h200;
    @(negedge clk);
    base_we = 1'b0;
    while (!resp_valid) @(negedge clk);
    @(negedge clk);
    do_req(6'd22, 0, 0, 0);
    // R9 write in the acceptance cycle: old base used, new one afterwards
    req_vaddr = 6'd50; req_write = 0; req_user = 0; req_valid = 1'b1;
    base_we = 1'b1; base_wdata = 32'h300;
    @(negedge clk);
    req_valid = 1'b0; base_we = 1'b0;
    while (!resp_valid) @(negedge clk);
    @(negedge clk);
    do_req(6'd50, 0, 0, 0);
    // R3 back-to-back requests with the response taken at once
    addr_tag = "R3";
    lat = 1;
    for (int i = 0; i < 8; i++) do_req(6'(i * 7 + 1), i % 2, (i / 2) % 2, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule